// File: doc/BRIEF.md
# Dual Flash Lane and Select Router

This block sits between a quad-lane serial flash transfer engine and up to two identical flash devices. The engine supplies one active-low select, a serial clock, a direction flag and a data word. A small configuration register decides how these reach the devices. In single mode one device is used. In stacked mode two devices share one clock and one four-lane bus, with a page bit choosing which select line goes active. In parallel mode both devices are selected together, each on its own four-lane bus.

In parallel mode each engine word is split bitwise. Even-numbered bits form the stream for the lower device on bus 0. Odd-numbered bits form the stream for the upper device on bus 1. Each 8-bit stream is sent as two nibbles, high nibble first, selected by the engine's phase input. On reads the two returned streams are merged back into one word. In single and stacked modes the low byte of the word travels on bus 0 in the same nibble order.

All device-side outputs and the read result are registered. They reflect the engine inputs sampled at the previous rising clock edge. Register writes made while the select is active are held until the select goes inactive.

Top module: `flash_lane_router`

## Requirements
- R1: After synchronous reset, both device selects are inactive (high), both bus clocks are low, no lane is driven, `eng_rx_valid` is low, and the active mode is single.
- R2: When config bit 30 is clear the mode is single, whatever bits 29 and 28 hold. `flash_cs_lo_n` follows `eng_cs_n` one cycle later. `flash_cs_up_n` stays high, and `bus1_sclk` and `bus1_oe` stay low.
- R3: When bit 30 is set and bit 29 is clear the mode is stacked. Bit 28 = 1 routes the select to `flash_cs_up_n` and bit 28 = 0 routes it to `flash_cs_lo_n`. Only one select is ever active. Clock and lanes use bus 0 only.
- R4: When bits 30 and 29 are both set the mode is parallel, and bit 28 is ignored. Both selects follow `eng_cs_n` together, and both bus clocks follow `eng_sclk`, one cycle later.
- R5: In parallel writes, bus 0 carries the lower stream L[k] = word[2k] and bus 1 carries the upper stream U[k] = word[2k+1]. Phase 0 sends bits [7:4] of each stream and phase 1 sends bits [3:0].
- R6: In single and stacked writes, bus 0 carries `eng_tx_word[7:4]` in phase 0 and `eng_tx_word[3:0]` in phase 1.
- R7: A bus output enable is high one cycle after the select is active with `eng_dir` = 1 (1 = write to the device), and only for a bus in use. Bus 1 is in use only in parallel mode. When its enable is low, a bus's lane outputs are 0.
- R8: In parallel reads, after the phase-1 beat the result rebuilds bit 2k from bus 0 stream bit k and bit 2k+1 from bus 1 stream bit k. The stream bit order is the same as in R5.
- R9: In single and stacked reads, the result holds the bus 0 byte (phase 0 is the high nibble) in bits [7:0], with bits [15:8] = 0, and bus 1 inputs are ignored. In all modes `eng_rx_valid` pulses high for one cycle, in the cycle after the phase-1 read beat (`eng_beat` = 1, `eng_dir` = 0).
- R10: A config write while `eng_cs_n` is low does not change routing during that transfer. It takes effect at the first clock edge where `eng_cs_n` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Config register write strobe |
| cfg_wdata | input | 32 | Config data: bit 30 two devices, bit 29 separate buses, bit 28 upper page |
| eng_cs_n | input | 1 | Engine select, active low |
| eng_sclk | input | 1 | Engine serial clock |
| eng_dir | input | 1 | 1 = drive lanes to device, 0 = read |
| eng_beat | input | 1 | Read beat: capture bus inputs this cycle |
| eng_phase | input | 1 | Nibble index, 0 = high nibble |
| eng_tx_word | input | 16 | Word to send |
| eng_rx_word | output | 16 | Assembled read word |
| eng_rx_valid | output | 1 | One-cycle pulse when eng_rx_word is new |
| flash_cs_lo_n | output | 1 | Lower device select, active low |
| flash_cs_up_n | output | 1 | Upper device select, active low |
| bus0_sclk | output | 1 | Bus 0 clock (lower device, shared in stacked mode) |
| bus0_o | output | 4 | Bus 0 lane outputs |
| bus0_oe | output | 1 | Bus 0 lane output enable |
| bus0_i | input | 4 | Bus 0 lane inputs |
| bus1_sclk | output | 1 | Bus 1 clock (upper device, parallel mode) |
| bus1_o | output | 4 | Bus 1 lane outputs |
| bus1_oe | output | 1 | Bus 1 lane output enable |
| bus1_i | input | 4 | Bus 1 lane inputs |

## Verification
Writes and reads are tried in each of the three modes. The configurations include one with the separate-bus and page bits set while two-device operation is off, to show that single mode ignores them. Alternating patterns 0xAAAA and 0x5555 put all ones on one device and all zeros on the other, which separates an even/odd swap from a correct split. Asymmetric words such as 0x1234, 0xF00F and 0x8001 catch nibble-order and bit-reversal faults in both the split and the merge. In stacked and single reads, bus 1 is fed a non-zero nibble to show it is ignored. A directed sequence writes parallel mode mid-transfer and shows that the upper select stays idle until the next select cycle.

// File: rtl/flr_pkg.sv
package flr_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_STACK  = 2'd1,
    MODE_PAR    = 2'd2
  } flr_mode_e;
endpackage

// File: rtl/flr_cfg_reg.sv
module flr_cfg_reg
  import flr_pkg::*;
#(
  parameter int CFG_W       = 32,
  parameter int TWO_MEM_BIT = 30,
  parameter int SEP_BUS_BIT = 29,
  parameter int UPPER_BIT   = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             sel_active,
  output flr_mode_e        mode,
  output logic             upper_sel
);
  localparam logic [CFG_W-1:0] FIELD_MASK =
    (CFG_W'(1) << TWO_MEM_BIT) | (CFG_W'(1) << SEP_BUS_BIT) | (CFG_W'(1) << UPPER_BIT);

  // stored fields: {two_mem, sep_bus, upper}
  logic [2:0] cur_q, pend_q, wr_fields;
  logic       pend_v;
  logic       unused_cfg_bits;

  assign wr_fields = {cfg_wdata[TWO_MEM_BIT], cfg_wdata[SEP_BUS_BIT], cfg_wdata[UPPER_BIT]};
  assign unused_cfg_bits = ^(cfg_wdata & ~FIELD_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= 3'b000;
      pend_q <= 3'b000;
      pend_v <= 1'b0;
    end else if (!sel_active) begin
      if (cfg_wr)      cur_q <= wr_fields;
      else if (pend_v) cur_q <= pend_q;
      pend_v <= 1'b0;
    end else if (cfg_wr) begin
      pend_q <= wr_fields;
      pend_v <= 1'b1;
    end
  end

  always_comb begin
    if (!cur_q[2])     mode = MODE_SINGLE;
    else if (cur_q[1]) mode = MODE_PAR;
    else               mode = MODE_STACK;
  end
  assign upper_sel = cur_q[0];

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_active && $past(sel_active) && $past(!rst)) |-> $stable(cur_q));

  // R10
  defer_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && sel_active) |=> pend_v);
endmodule

// File: rtl/flr_select.sv
module flr_select
  import flr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flr_mode_e mode,
  input  logic      upper_sel,
  input  logic      eng_cs_n,
  input  logic      eng_sclk,
  output logic      cs_lo_n,
  output logic      cs_up_n,
  output logic      sclk0,
  output logic      sclk1
);
  logic lo_en, up_en, par;

  always_comb begin
    par   = (mode == MODE_PAR);
    lo_en = (mode == MODE_SINGLE) || par || ((mode == MODE_STACK) && !upper_sel);
    up_en = par || ((mode == MODE_STACK) && upper_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_lo_n <= 1'b1;
      cs_up_n <= 1'b1;
      sclk0   <= 1'b0;
      sclk1   <= 1'b0;
    end else begin
      cs_lo_n <= lo_en ? eng_cs_n : 1'b1;
      cs_up_n <= up_en ? eng_cs_n : 1'b1;
      sclk0   <= eng_sclk;
      sclk1   <= par & eng_sclk;
    end
  end

  // R4
  par_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mode == MODE_PAR) |-> (cs_lo_n == cs_up_n));

  // R3
  one_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mode != MODE_PAR) |-> $onehot0({~cs_lo_n, ~cs_up_n}));

  // R2
  single_up_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mode == MODE_SINGLE) |-> (cs_up_n && !sclk1));
endmodule

// File: rtl/flr_tx_lanes.sv
module flr_tx_lanes
  import flr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LANES  = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  flr_mode_e                              mode,
  input  logic                                   sel_active,
  input  logic                                   dir,
  input  logic [$clog2(WORD_W/(2*LANES))-1:0]    phase,
  input  logic [WORD_W-1:0]                      word,
  output logic [LANES-1:0]                       bus0_o,
  output logic                                   bus0_oe,
  output logic [LANES-1:0]                       bus1_o,
  output logic                                   bus1_oe
);
  localparam int STREAM_W = WORD_W / 2;
  localparam int NIBS     = STREAM_W / LANES;
  localparam int PH_W     = $clog2(NIBS);

  logic [STREAM_W-1:0] lo_str, up_str;
  logic [LANES-1:0]    lo_nib, up_nib, byte_nib;
  logic                drive, par;

  generate
    for (genvar k = 0; k < STREAM_W; k++) begin : g_split
      assign lo_str[k] = word[2*k];
      assign up_str[k] = word[2*k+1];
    end
  endgenerate

  // phase 0 picks the most significant nibble of each stream
  always_comb begin
    lo_nib   = '0;
    up_nib   = '0;
    byte_nib = '0;
    for (int n = 0; n < NIBS; n++) begin
      if (phase == PH_W'(NIBS - 1 - n)) begin
        lo_nib   = lo_str[n*LANES +: LANES];
        up_nib   = up_str[n*LANES +: LANES];
        byte_nib = word[n*LANES +: LANES];
      end
    end
  end

  assign drive = sel_active && dir;
  assign par   = (mode == MODE_PAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus0_o  <= '0;
      bus0_oe <= 1'b0;
      bus1_o  <= '0;
      bus1_oe <= 1'b0;
    end else begin
      bus0_oe <= drive;
      bus1_oe <= drive && par;
      bus0_o  <= drive ? (par ? lo_nib : byte_nib) : '0;
      bus1_o  <= (drive && par) ? up_nib : '0;
    end
  end

  // R7
  bus1_par_chk: assert property (@(posedge clk) disable iff (rst)
    bus1_oe |-> $past(mode == MODE_PAR));

  // R7
  oe_dir_chk: assert property (@(posedge clk) disable iff (rst)
    bus0_oe |-> $past(dir && sel_active));

  // R7
  idle_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus0_oe && !bus1_oe) |-> (bus0_o == '0 && bus1_o == '0));
endmodule

// File: rtl/flr_rx_merge.sv
module flr_rx_merge
  import flr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LANES  = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  flr_mode_e                              mode,
  input  logic                                   sel_active,
  input  logic                                   dir,
  input  logic                                   beat,
  input  logic [$clog2(WORD_W/(2*LANES))-1:0]    phase,
  input  logic [LANES-1:0]                       bus0_i,
  input  logic [LANES-1:0]                       bus1_i,
  output logic [WORD_W-1:0]                      rx_word,
  output logic                                   rx_valid
);
  localparam int STREAM_W = WORD_W / 2;
  localparam int NIBS     = STREAM_W / LANES;
  localparam int PH_W     = $clog2(NIBS);
  localparam int ACC_W    = STREAM_W - LANES;

  logic [ACC_W-1:0]    lo_acc, up_acc;
  logic [STREAM_W-1:0] lo_next, up_next;
  logic [WORD_W-1:0]   merged;
  logic                cap, last;

  assign cap     = sel_active && !dir && beat;
  assign last    = (phase == PH_W'(NIBS - 1));
  assign lo_next = {lo_acc, bus0_i};
  assign up_next = {up_acc, bus1_i};

  generate
    for (genvar k = 0; k < STREAM_W; k++) begin : g_merge
      assign merged[2*k]   = lo_next[k];
      assign merged[2*k+1] = up_next[k];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_acc   <= '0;
      up_acc   <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= cap && last;
      if (cap) begin
        lo_acc <= lo_next[ACC_W-1:0];
        up_acc <= up_next[ACC_W-1:0];
        if (last)
          rx_word <= (mode == MODE_PAR) ? merged
                                        : {{(WORD_W-STREAM_W){1'b0}}, lo_next};
      end
    end
  end

  // R9
  rx_src_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(beat && !dir && sel_active));

  // R9
  rx_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && $past(mode != MODE_PAR)) |-> (rx_word[WORD_W-1:STREAM_W] == '0));
endmodule

// File: rtl/flash_lane_router.sv
module flash_lane_router
  import flr_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int LANES       = 4,
  parameter int CFG_W       = 32,
  parameter int TWO_MEM_BIT = 30,
  parameter int SEP_BUS_BIT = 29,
  parameter int UPPER_BIT   = 28
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cfg_wr,
  input  logic [CFG_W-1:0]                    cfg_wdata,
  input  logic                                eng_cs_n,
  input  logic                                eng_sclk,
  input  logic                                eng_dir,
  input  logic                                eng_beat,
  input  logic [$clog2(WORD_W/(2*LANES))-1:0] eng_phase,
  input  logic [WORD_W-1:0]                   eng_tx_word,
  output logic [WORD_W-1:0]                   eng_rx_word,
  output logic                                eng_rx_valid,
  output logic                                flash_cs_lo_n,
  output logic                                flash_cs_up_n,
  output logic                                bus0_sclk,
  output logic [LANES-1:0]                    bus0_o,
  output logic                                bus0_oe,
  input  logic [LANES-1:0]                    bus0_i,
  output logic                                bus1_sclk,
  output logic [LANES-1:0]                    bus1_o,
  output logic                                bus1_oe,
  input  logic [LANES-1:0]                    bus1_i
);
  flr_mode_e mode;
  logic      upper_sel;
  logic      sel_active;

  assign sel_active = !eng_cs_n;

  flr_cfg_reg #(
    .CFG_W(CFG_W), .TWO_MEM_BIT(TWO_MEM_BIT),
    .SEP_BUS_BIT(SEP_BUS_BIT), .UPPER_BIT(UPPER_BIT)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .sel_active(sel_active), .mode(mode), .upper_sel(upper_sel)
  );

  flr_select u_sel (
    .clk(clk), .rst(rst), .mode(mode), .upper_sel(upper_sel),
    .eng_cs_n(eng_cs_n), .eng_sclk(eng_sclk),
    .cs_lo_n(flash_cs_lo_n), .cs_up_n(flash_cs_up_n),
    .sclk0(bus0_sclk), .sclk1(bus1_sclk)
  );

  flr_tx_lanes #(.WORD_W(WORD_W), .LANES(LANES)) u_tx (
    .clk(clk), .rst(rst), .mode(mode), .sel_active(sel_active),
    .dir(eng_dir), .phase(eng_phase), .word(eng_tx_word),
    .bus0_o(bus0_o), .bus0_oe(bus0_oe), .bus1_o(bus1_o), .bus1_oe(bus1_oe)
  );

  flr_rx_merge #(.WORD_W(WORD_W), .LANES(LANES)) u_rx (
    .clk(clk), .rst(rst), .mode(mode), .sel_active(sel_active),
    .dir(eng_dir), .beat(eng_beat), .phase(eng_phase),
    .bus0_i(bus0_i), .bus1_i(bus1_i),
    .rx_word(eng_rx_word), .rx_valid(eng_rx_valid)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (flash_cs_lo_n && flash_cs_up_n && !bus0_oe && !bus1_oe && !eng_rx_valid));
endmodule

// File: tb/sim_flash_lane_router.sv
module sim_flash_lane_router;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr;
  logic [31:0] cfg_wdata;
  logic        eng_cs_n, eng_sclk, eng_dir, eng_beat;
  logic [0:0]  eng_phase;
  logic [15:0] eng_tx_word;
  logic [15:0] eng_rx_word;
  logic        eng_rx_valid;
  logic        flash_cs_lo_n, flash_cs_up_n;
  logic        bus0_sclk, bus0_oe, bus1_sclk, bus1_oe;
  logic [3:0]  bus0_o, bus1_o, bus0_i, bus1_i;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_lane_router u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .eng_cs_n(eng_cs_n), .eng_sclk(eng_sclk), .eng_dir(eng_dir),
    .eng_beat(eng_beat), .eng_phase(eng_phase), .eng_tx_word(eng_tx_word),
    .eng_rx_word(eng_rx_word), .eng_rx_valid(eng_rx_valid),
    .flash_cs_lo_n(flash_cs_lo_n), .flash_cs_up_n(flash_cs_up_n),
    .bus0_sclk(bus0_sclk), .bus0_o(bus0_o), .bus0_oe(bus0_oe), .bus0_i(bus0_i),
    .bus1_sclk(bus1_sclk), .bus1_o(bus1_o), .bus1_oe(bus1_oe), .bus1_i(bus1_i)
  );

  // vector: [19:17] {two_mem, sep_bus, upper}, [16] dir (1 = write), [15:0] word
  localparam logic [19:0] VEC [12] = '{
    {3'b000, 1'b1, 16'h1234},
    {3'b011, 1'b1, 16'h00A5},
    {3'b100, 1'b1, 16'h00C3},
    {3'b101, 1'b1, 16'h003C},
    {3'b110, 1'b1, 16'hAAAA},
    {3'b110, 1'b1, 16'h5555},
    {3'b111, 1'b1, 16'h1234},
    {3'b110, 1'b0, 16'hF00F},
    {3'b100, 1'b0, 16'h0096},
    {3'b000, 1'b0, 16'h005A},
    {3'b110, 1'b0, 16'h8001},
    {3'b101, 1'b0, 16'h00E7}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] even_bits(input logic [15:0] w);
    for (int k = 0; k < 8; k++) even_bits[k] = w[2*k];
  endfunction

  function automatic logic [7:0] odd_bits(input logic [15:0] w);
    for (int k = 0; k < 8; k++) odd_bits[k] = w[2*k+1];
  endfunction

  task automatic write_cfg(input logic [2:0] c);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = 32'(c) << 28;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic xfer(input logic [2:0] c, input logic d, input logic [15:0] w);
    logic two, sep, up, par, lo_act, up_act;
    logic [7:0] ls, us;
    logic [3:0] n0, n1;
    string selt, datt, rxt;
    two = c[2]; sep = c[1]; up = c[0];
    par    = two && sep;
    lo_act = !two || sep || !up;
    up_act = two && (sep || up);
    selt = !two ? "R2 select" : (par ? "R4 select" : "R3 select");
    datt = par ? "R5 data" : "R6 data";
    rxt  = par ? "R8 read" : "R9 read";
    ls = even_bits(w);
    us = odd_bits(w);
    write_cfg(c);
    for (int p = 0; p < 2; p++) begin
      @(negedge clk);
      eng_cs_n = 1'b0; eng_sclk = 1'b1; eng_dir = d; eng_beat = 1'b1;
      eng_phase = p[0:0]; eng_tx_word = w;
      n0 = par ? (p == 0 ? ls[7:4] : ls[3:0]) : (p == 0 ? w[7:4] : w[3:0]);
      n1 = (p == 0) ? us[7:4] : us[3:0];
      bus0_i = d ? 4'h0 : n0;
      bus1_i = d ? 4'h0 : (par ? n1 : 4'h9);
      @(posedge clk); #1;
      chk({selt, " lo"}, 32'(flash_cs_lo_n), 32'(!lo_act));
      chk({selt, " up"}, 32'(flash_cs_up_n), 32'(!up_act));
      chk({selt, " sclk0"}, 32'(bus0_sclk), 32'd1);
      chk({selt, " sclk1"}, 32'(bus1_sclk), 32'(par));
      chk("R7 oe0", 32'(bus0_oe), 32'(d));
      chk("R7 oe1", 32'(bus1_oe), 32'(d && par));
      if (d) begin
        chk({datt, " bus0"}, 32'(bus0_o), 32'(n0));
        chk({datt, " bus1"}, 32'(bus1_o), par ? 32'(n1) : 32'd0);
      end else begin
        chk("R7 idle lanes", 32'({bus0_o, bus1_o}), 32'd0);
        chk({rxt, " valid"}, 32'(eng_rx_valid), (p == 1) ? 32'd1 : 32'd0);
        if (p == 1)
          chk({rxt, " word"}, 32'(eng_rx_word), par ? 32'(w) : 32'({8'h00, w[7:0]}));
      end
    end
    @(negedge clk);
    eng_cs_n = 1'b1; eng_sclk = 1'b0; eng_beat = 1'b0; eng_dir = 1'b0;
    @(posedge clk); #1;
    chk("R9 valid pulse end", 32'(eng_rx_valid), 32'd0);
    chk({selt, " release"}, 32'({flash_cs_lo_n, flash_cs_up_n}), 32'd3);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_wr = 1'b0; cfg_wdata = '0;
    eng_cs_n = 1'b1; eng_sclk = 1'b0; eng_dir = 1'b0; eng_beat = 1'b0;
    eng_phase = '0; eng_tx_word = '0; bus0_i = '0; bus1_i = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    // R1: reset state
    chk("R1 cs_lo", 32'(flash_cs_lo_n), 32'd1);
    chk("R1 cs_up", 32'(flash_cs_up_n), 32'd1);
    chk("R1 oe", 32'({bus0_oe, bus1_oe}), 32'd0);
    chk("R1 sclk", 32'({bus0_sclk, bus1_sclk}), 32'd0);
    chk("R1 rx_valid", 32'(eng_rx_valid), 32'd0);
    // R1: default mode is single
    @(negedge clk); eng_cs_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 default single lo", 32'(flash_cs_lo_n), 32'd0);
    chk("R1 default single up", 32'(flash_cs_up_n), 32'd1);
    @(negedge clk); eng_cs_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < 12; i++)
      xfer(VEC[i][19:17], VEC[i][16], VEC[i][15:0]);

    // R10: config write during an active select is deferred
    write_cfg(3'b000);
    @(negedge clk); eng_cs_n = 1'b0; eng_sclk = 1'b1;
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 32'(3'b110) << 28;
    @(negedge clk); cfg_wr = 1'b0;
    @(posedge clk); #1;
    chk("R10 held up select", 32'(flash_cs_up_n), 32'd1);
    chk("R10 held bus1 clock", 32'(bus1_sclk), 32'd0);
    @(negedge clk); eng_cs_n = 1'b1; eng_sclk = 1'b0;
    @(negedge clk); eng_cs_n = 1'b0; eng_sclk = 1'b1;
    @(posedge clk); #1;
    chk("R10 applied up select", 32'(flash_cs_up_n), 32'd0);
    chk("R10 applied lo select", 32'(flash_cs_lo_n), 32'd0);
    chk("R10 applied bus1 clock", 32'(bus1_sclk), 32'd1);
    @(negedge clk); eng_cs_n = 1'b1; eng_sclk = 1'b0;
    @(posedge clk); #1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule